// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache placed between a processor load/store port and a single-word lower-level memory port. A 32-bit byte address is decoded into a tag, a line index, a word-in-line select and a byte select. Each line holds a valid flag, a tag and a block of 32-bit words. A load whose line is valid and whose tag matches returns data from the cache. A load that misses holds the processor. The whole block is fetched from memory one word at a time, and the access then replays and completes as a hit.

Stores are write-through. A store that hits updates the selected bytes in the line and places address, data and byte mask into a small FIFO write buffer. The buffer drains to memory whenever the memory port is free. A store waits while the buffer is full. A store that misses first fills the whole block and then merges its bytes into the line. A fill never starts until every buffered store has reached memory, so a refetch cannot return stale data.

With the default `IDX_W = 8`, the cache has 256 lines of 16 bytes each. Setting `IDX_W = 12` gives the 64 KB, 4096-line configuration, with a 16-bit tag.

Top module: `dc_wt_cache`

## Requirements
- R1: Synchronous active-high reset clears every valid flag and drives `cpu_ready` and `mem_req` low. The first load to any address after reset is therefore a miss.
- R2: The byte address is split as follows: bits [1:0] select the byte, bits [3:2] select the word within the 4-word line, bits [IDX_W+3:4] form the index, and the remaining upper bits form the tag. A load returns the word selected by bits [3:2].
- R3: A load or store that hits, with room in the write buffer, raises `cpu_ready` for exactly one cycle, 2 clock edges after the request is sampled. No memory read is issued for it.
- R4: A load miss reads the 4 words of the block from memory at the block base plus 0, 4, 8 and 12, in that order. Each read has `mem_we` = 0 and `mem_be` = 4'b1111. The load then completes with the requested word.
- R5: Two addresses with the same index and different tags evict each other. Accessing one after the other is a miss.
- R6: Every store is written to memory exactly once, in program order, with the store's address, data and byte mask. A later miss on that block therefore sees the stored data.
- R7: The write buffer holds 4 stores. A store that finds it full does not complete until an entry has drained to memory.
- R8: A block fetch issues no memory read while any store remains in the write buffer or a memory write is outstanding.
- R9: A store miss fills the whole block from memory, then merges the store. A later load of that word returns the merged value without a miss.
- R10: Byte-mask bit k (0 to 3) controls byte k, which is data bits [8k+7:8k]. Only bytes whose mask bit is 1 change in the cached word, and the mask is forwarded to memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_be | input | 4 | Store byte mask |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte mask |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The properties assume that the processor holds `cpu_req`, `cpu_addr`, `cpu_we`, `cpu_be` and `cpu_wdata` steady from request until `cpu_ready`. They also assume that memory answers each request with exactly one `mem_ack` pulse, and only while `mem_req` is high. The stimulus changes processor inputs only on the falling edge after a completion pulse. The memory model acknowledges only a pending request, after a programmable delay, and drops the acknowledge on the following cycle. A long delay is used to fill the write buffer and to hold a block fetch behind queued stores.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int BOFF_W = $clog2(BE_W);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
  } dc_wr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_DRAIN,
    ST_FILL,
    ST_REFETCH
  } dc_state_t;
endpackage

// File: rtl/dc_tag_ram.sv
module dc_tag_ram #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tags [LINES];
  logic [LINES-1:0] valid;

  // tag array: plain synchronous RAM
  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_idx] <= wr_tag;
    rd_tag <= tags[rd_idx];
  end

  // valid flags live in flops so reset can clear them
  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid[wr_idx] <= 1'b1;
      rd_valid <= valid[rd_idx];
    end
  end
endmodule

// File: rtl/dc_data_ram.sv
module dc_data_ram #(
  parameter int IDX_W = 8,
  parameter int WORDS = 4
) (
  input  logic                            clk,
  input  logic [IDX_W-1:0]                rd_idx,
  output logic [WORDS*dc_pkg::DATA_W-1:0] rd_line,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [$clog2(WORDS)-1:0]        wr_word,
  input  logic [dc_pkg::BE_W-1:0]         wr_be,
  input  logic [dc_pkg::DATA_W-1:0]       wr_data
);
  import dc_pkg::*;
  localparam int LINES  = 1 << IDX_W;
  localparam int WOFF_W = $clog2(WORDS);

  for (genvar w = 0; w < WORDS; w++) begin : g_bank
    logic [DATA_W-1:0] bank [LINES];
    always_ff @(posedge clk) begin
      if (wr_en && wr_word == WOFF_W'(w)) begin
        for (int b = 0; b < BE_W; b++) begin
          if (wr_be[b]) bank[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
      rd_line[w*DATA_W +: DATA_W] <= bank[rd_idx];
    end
  end
endmodule

// File: rtl/dc_wbuf.sv
module dc_wbuf #(
  parameter int DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  dc_pkg::dc_wr_t push_ent,
  input  logic           pop,
  output dc_pkg::dc_wr_t head,
  output logic           empty,
  output logic           full
);
  import dc_pkg::*;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  dc_wr_t           q [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [PTR_W:0]   cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == (PTR_W+1)'(DEPTH));
  assign head  = q[rp];

  always_ff @(posedge clk) begin
    if (push) q[wp] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PTR_W'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PTR_W'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dc_wt_cache.sv
module dc_wt_cache #(
  parameter int IDX_W      = 8,
  parameter int WORDS      = 4,
  parameter int WBUF_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [3:0]  cpu_be,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ready,
  output logic [31:0] cpu_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  import dc_pkg::*;
  localparam int WOFF_W = $clog2(WORDS);
  localparam int LO_W   = WOFF_W + BOFF_W;
  localparam int TAG_W  = ADDR_W - IDX_W - LO_W;

  dc_state_t state;

  // address fields
  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WOFF_W-1:0] a_word;
  assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_idx  = cpu_addr[LO_W +: IDX_W];
  assign a_word = cpu_addr[BOFF_W +: WOFF_W];

  // array outputs
  logic [TAG_W-1:0]        rd_tag;
  logic                    rd_valid;
  logic [WORDS*DATA_W-1:0] rd_line;
  logic                    hit;
  assign hit = rd_valid && (rd_tag == a_tag);

  // write-buffer wiring
  dc_wr_t wb_head, wb_in;
  logic   wb_push, wb_pop, wb_empty, wb_full;

  // registered outputs
  logic              ready_q, mreq_q, mwe_q;
  logic [DATA_W-1:0] rdata_q, mwdata_q;
  logic [ADDR_W-1:0] maddr_q;
  logic [BE_W-1:0]   mbe_q;
  logic [WOFF_W-1:0] fill_cnt;

  logic store_ok, fill_wr, drain_go, fill_last;
  assign store_ok  = (state == ST_LOOK) && hit && cpu_req && cpu_we && !wb_full;
  assign fill_wr   = (state == ST_FILL) && mreq_q && mem_ack;
  assign fill_last = (fill_cnt == WOFF_W'(WORDS-1));
  assign drain_go  = !mreq_q && !wb_empty && (state != ST_FILL);

  assign wb_push    = store_ok;
  assign wb_pop     = drain_go;
  assign wb_in.addr = {cpu_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
  assign wb_in.data = cpu_wdata;
  assign wb_in.be   = cpu_be;

  dc_tag_ram #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (a_idx),
    .rd_tag   (rd_tag),
    .rd_valid (rd_valid),
    .wr_en    (fill_wr && fill_last),
    .wr_idx   (a_idx),
    .wr_tag   (a_tag)
  );

  dc_data_ram #(.IDX_W(IDX_W), .WORDS(WORDS)) u_data (
    .clk     (clk),
    .rd_idx  (a_idx),
    .rd_line (rd_line),
    .wr_en   (fill_wr || store_ok),
    .wr_idx  (a_idx),
    .wr_word (fill_wr ? fill_cnt : a_word),
    .wr_be   (fill_wr ? {BE_W{1'b1}} : cpu_be),
    .wr_data (fill_wr ? mem_rdata : cpu_wdata)
  );

  dc_wbuf #(.DEPTH(WBUF_DEPTH)) u_wbuf (
    .clk      (clk),
    .rst      (rst),
    .push     (wb_push),
    .push_ent (wb_in),
    .pop      (wb_pop),
    .head     (wb_head),
    .empty    (wb_empty),
    .full     (wb_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ready_q  <= 1'b0;
      rdata_q  <= '0;
      mreq_q   <= 1'b0;
      mwe_q    <= 1'b0;
      maddr_q  <= '0;
      mwdata_q <= '0;
      mbe_q    <= '0;
      fill_cnt <= '0;
    end else begin
      ready_q <= 1'b0;
      if (mreq_q && mem_ack) mreq_q <= 1'b0;

      // drain engine: oldest store goes out when the port is free
      if (drain_go) begin
        mreq_q   <= 1'b1;
        mwe_q    <= 1'b1;
        maddr_q  <= wb_head.addr;
        mwdata_q <= wb_head.data;
        mbe_q    <= wb_head.be;
      end

      case (state)
        ST_IDLE: if (cpu_req) state <= ST_LOOK;
        ST_LOOK: begin
          if (hit) begin
            if (!cpu_we) begin
              rdata_q <= rd_line[a_word*DATA_W +: DATA_W];
              ready_q <= 1'b1;
              state   <= ST_IDLE;
            end else if (!wb_full) begin
              ready_q <= 1'b1;
              state   <= ST_IDLE;
            end
          end else begin
            state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (wb_empty && !mreq_q) begin
            fill_cnt <= '0;
            state    <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (!mreq_q) begin
            mreq_q  <= 1'b1;
            mwe_q   <= 1'b0;
            maddr_q <= {a_tag, a_idx, fill_cnt, {BOFF_W{1'b0}}};
            mbe_q   <= {BE_W{1'b1}};
          end else if (mem_ack) begin
            fill_cnt <= fill_cnt + 1'b1;
            if (fill_last) state <= ST_REFETCH;
          end
        end
        ST_REFETCH: state <= ST_LOOK;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = ready_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = mreq_q;
  assign mem_we    = mwe_q;
  assign mem_addr  = maddr_q;
  assign mem_wdata = mwdata_q;
  assign mem_be    = mbe_q;
endmodule

// File: rtl/dc_wt_cache_chk.sv
module dc_wt_cache_chk #(
  parameter int DEPTH = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        cpu_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        wb_push,
  input logic        wb_pop,
  input logic        wb_full,
  input logic        wb_empty
);
  int occ;

  always_ff @(posedge clk) begin
    if (rst) occ <= 0;
    else     occ <= occ + int'(wb_push) - int'(wb_pop);
  end

  // R1: reset leaves no completion and no memory request
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!cpu_ready && !mem_req));

  // R3: completion is a single-cycle pulse
  assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R6: a memory request holds its address and direction until acknowledged
  assert_mem_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7: buffer full flag agrees with the push/pop history and never overflows
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (occ <= DEPTH) && ((occ == DEPTH) == wb_full));

  // R8: a fill read is only outstanding with an empty write buffer
  assert_fill_after_drain_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> wb_empty);
endmodule

bind dc_wt_cache dc_wt_cache_chk #(.DEPTH(WBUF_DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .wb_push   (wb_push),
  .wb_pop    (wb_pop),
  .wb_full   (wb_full),
  .wb_empty  (wb_empty)
);

// File: tb/sim_dc_wt_cache.sv
module sim_dc_wt_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [3:0]  cpu_be = 4'h0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_wt_cache u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  // memory model with transaction log
  logic [31:0] mmem [logic [31:0]];
  logic [31:0] rmem [logic [31:0]];
  int          mem_lat = 1;
  int          mcnt = 0;
  logic        log_we   [4096];
  logic [31:0] log_addr [4096];
  logic [31:0] log_data [4096];
  logic [3:0]  log_be   [4096];
  int          log_n = 0;

  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      mcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      mcnt++;
      if (mcnt >= mem_lat) begin
        mcnt = 0;
        mem_ack = 1'b1;
        if (mem_we) begin
          mmem[mem_addr] = merge(mmem.exists(mem_addr) ? mmem[mem_addr] : pat(mem_addr),
                                 mem_wdata, mem_be);
        end else begin
          mem_rdata = mmem.exists(mem_addr) ? mmem[mem_addr] : pat(mem_addr);
        end
        if (log_n < 4096) begin
          log_we[log_n] = mem_we; log_addr[log_n] = mem_addr;
          log_data[log_n] = mem_wdata; log_be[log_n] = mem_be;
          log_n++;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rref(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    return rmem.exists(w) ? rmem[w] : pat(w);
  endfunction

  task automatic do_op(input logic we, input logic [3:0] be, input logic [31:0] a,
                       input logic [31:0] wd, output logic [31:0] rd,
                       output int lat, output int nrd);
    int start;
    logic [31:0] w;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_be = be; cpu_addr = a; cpu_wdata = wd;
    start = log_n;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpu_ready && lat < 20000);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    nrd = 0;
    for (int i = start; i < log_n; i++) if (!log_we[i]) nrd++;
    if (we) begin
      w = {a[31:2], 2'b00};
      rmem[w] = merge(rref(w), wd, be);
    end
  endtask

  typedef struct packed {
    logic        we;
    logic        miss;
    logic [3:0]  be;
    logic [31:0] addr;
    logic [31:0] wd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{we:1'b0, miss:1'b1, be:4'h0, addr:32'h0000_1000, wd:32'h0},            // R1 R4
    '{we:1'b0, miss:1'b0, be:4'h0, addr:32'h0000_1004, wd:32'h0},            // R2 R3
    '{we:1'b0, miss:1'b0, be:4'h0, addr:32'h0000_100C, wd:32'h0},            // R2
    '{we:1'b1, miss:1'b0, be:4'hF, addr:32'h0000_1008, wd:32'hDEAD_BEEF},    // R3
    '{we:1'b0, miss:1'b0, be:4'h0, addr:32'h0000_1008, wd:32'h0},
    '{we:1'b0, miss:1'b1, be:4'h0, addr:32'h0000_2000, wd:32'h0},            // R5
    '{we:1'b0, miss:1'b1, be:4'h0, addr:32'h0000_1008, wd:32'h0},            // R5 R6
    '{we:1'b1, miss:1'b1, be:4'h3, addr:32'h0000_3014, wd:32'h1234_5678},    // R9
    '{we:1'b0, miss:1'b0, be:4'h0, addr:32'h0000_3014, wd:32'h0},            // R9 R10
    '{we:1'b1, miss:1'b0, be:4'hC, addr:32'h0000_3014, wd:32'hAABB_CCDD},    // R10
    '{we:1'b0, miss:1'b0, be:4'h0, addr:32'h0000_3014, wd:32'h0},            // R10
    '{we:1'b0, miss:1'b1, be:4'h0, addr:32'hFFFF_FFF0, wd:32'h0},            // R2
    '{we:1'b0, miss:1'b0, be:4'h0, addr:32'hFFFF_FFFC, wd:32'h0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat, nrd, base, first_rd, nwr;
    logic order_ok;

    repeat (4) @(negedge clk);
    chk("R1 ready low in reset", {31'b0, cpu_ready}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 no mem request after reset", {31'b0, mem_req}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i].we, VEC[i].be, VEC[i].addr, VEC[i].wd, rd, lat, nrd);
      chk($sformatf("R3 R5 R9 vec%0d miss reads", i), nrd, VEC[i].miss ? 4 : 0);
      if (!VEC[i].miss) chk($sformatf("R3 vec%0d hit latency", i), lat, 2);
      if (!VEC[i].we) chk($sformatf("R2 R6 R10 vec%0d load data", i), rd, rref(VEC[i].addr));
    end

    // R4: fill order and direction
    base = log_n;
    do_op(1'b0, 4'h0, 32'h0000_6024, 32'h0, rd, lat, nrd);
    chk("R4 load data", rd, pat(32'h0000_6024));
    for (int k = 0; k < 4; k++) begin
      chk($sformatf("R4 fill addr %0d", k), log_addr[base+k], 32'h0000_6020 + 32'(4*k));
      chk($sformatf("R4 fill is read %0d", k), {31'b0, log_we[base+k]}, 32'h0);
      chk($sformatf("R4 fill mask %0d", k), {28'b0, log_be[base+k]}, 32'hF);
    end

    // R7, R8, R6: slow memory, back up the write buffer
    do_op(1'b0, 4'h0, 32'h0000_4000, 32'h0, rd, lat, nrd);
    mem_lat = 20;
    base = log_n;
    for (int s = 0; s < 6; s++) begin
      do_op(1'b1, 4'hF, 32'h0000_4000 + 32'(4*(s%4)), 32'hC0DE_0000 + 32'(s), rd, lat, nrd);
      if (s == 4) chk("R7 store into last free slot latency", lat, 2);
      if (s == 5) chk("R7 store stalls on full buffer", {31'b0, lat > 2}, 32'h1);
    end
    do_op(1'b0, 4'h0, 32'h0000_5000, 32'h0, rd, lat, nrd);
    chk("R8 fill data after drain", rd, pat(32'h0000_5000));
    first_rd = -1; nwr = 0; order_ok = 1'b1;
    for (int i = base; i < log_n; i++) begin
      if (!log_we[i] && first_rd < 0) first_rd = i;
      if (log_we[i]) begin
        if (first_rd >= 0) order_ok = 1'b0;
        if (log_addr[i] != 32'h0000_4000 + 32'(4*(nwr%4)) ||
            log_data[i] != 32'hC0DE_0000 + 32'(nwr)) order_ok = 1'b0;
        nwr++;
      end
    end
    chk("R8 all stores before fill read", {31'b0, order_ok}, 32'h1);
    chk("R6 store count in memory", nwr, 6);
    mem_lat = 1;

    // R1: reset invalidates lines
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    do_op(1'b0, 4'h0, 32'h0000_1000, 32'h0, rd, lat, nrd);
    chk("R1 first load after reset misses", nrd, 4);
    chk("R1 load data after reset", rd, rref(32'h0000_1000));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule